// File: doc/BRIEF.md
# Two-Level Interrupt Priority Arbiter

This block decides which interrupt request a small processor core services next. It watches up to eight request flags. Each flag has its own enable bit and a one-bit level bit (0 = low, 1 = high), and a global enable gates them all. Once per machine cycle the block picks one winner. A high-level request always beats a low-level one. Within a level, a fixed order by source index decides, and index 0 is served first.

When a winner is chosen, the block issues a one-clock acknowledge pulse together with the fixed call address for that source. In the same cycle it raises a one-hot per-source acknowledge, so that the owning peripheral can clear its flag. The block also records which levels are in service. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine. A return strobe from the core ends the innermost routine.

Top module: `int_prio_arb`

## Requirements
- R1: While reset is held, and directly after it, `ack_o` is 0, `src_ack_o` is all zeros, `insvc_o` is 2'b00 and `vec_o` is 0.
- R2: A grant to source index i drives `vec_o` = 16'h0003 + 8*i, so index 0 gets 0003H and index 7 gets 003BH.
- R3: Among pending, enabled requests of the same level, the lowest source index is granted.
- R4: A pending high-level request (`lvl_i` bit = 1) is granted ahead of any low-level request, whatever the indices.
- R5: A request whose `en_i` bit is 0 is never granted. While `glob_en_i` is 0, no request is granted.
- R6: While only the low level is in service (`insvc_o` = 2'b01), a high-level request is granted and `insvc_o` becomes 2'b11. A low-level request is not granted.
- R7: While the high level is in service (`insvc_o[1]` = 1), no request is granted.
- R8: A one-clock pulse on `reti_i` clears `insvc_o[1]` if it is set, and otherwise clears `insvc_o[0]`. A single pulse never clears both bits.
- R9: `ack_o` is a single-clock pulse. While it is high, `src_ack_o` is one-hot at the granted index, and the `insvc_o` bit of the granted level is set. At all other times `src_ack_o` is zero.
- R10: Arbitration runs at most once per machine cycle of `MC_LEN` clocks, so two acknowledges are at least `MC_LEN` clocks apart. A request that becomes eligible is granted within `MC_LEN`+1 clocks. `vec_o` holds its value between acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NSRC | Pending request flags, one per source |
| en_i | input | NSRC | Per-source enable |
| lvl_i | input | NSRC | Per-source level: 1 = high, 0 = low |
| glob_en_i | input | 1 | Global interrupt enable |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-clock acknowledge to the core |
| vec_o | output | ADDR_W | Call address of the granted source |
| src_ack_o | output | NSRC | One-hot per-source acknowledge that clears the flag |
| insvc_o | output | 2 | In-service bits: [1] high level, [0] low level |

## Verification
The bench instantiates the block with `MC_LEN` = 4 instead of the default 12, so the machine-cycle tick comes often. This lets every vector, nested pre-emption and return sequence fit in a short run. It keeps `NSRC` = 8 and the default address base and stride. As a result, all eight call addresses, including the top index at 003BH, are exercised and compared against values the bench computes itself. With the short machine cycle, the bench can also measure the latency bound from an eligible request to its acknowledge, and it can see a blocked request wait across several arbitration ticks.

// File: rtl/int_prio_arb_pkg.sv
package int_prio_arb_pkg;

  // Call address of a source: base plus index times stride.
  function automatic logic [31:0] vec_of(input int unsigned idx,
                                         input logic [31:0] base,
                                         input int unsigned step);
    return base + 32'(idx * step);
  endfunction

  // Lowest set bit index of a 32-bit mask (0 when the mask is empty).
  function automatic logic [4:0] lowest_set(input logic [31:0] m);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/arb_mc_timer.sv
module arb_mc_timer #(
  parameter int MC_LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(MC_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/arb_prio_select.sv
module arb_prio_select
  import int_prio_arb_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] lvl_i,
  input  logic            glob_en_i,
  input  logic [1:0]      insvc_i,
  output logic            vld_o,
  output logic [$clog2(NSRC)-1:0] idx_o,
  output logic            lvl_o
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] hi_mask, lo_mask;

  for (genvar g = 0; g < NSRC; g++) begin : g_mask
    assign hi_mask[g] = glob_en_i & req_i[g] & en_i[g] &  lvl_i[g];
    assign lo_mask[g] = glob_en_i & req_i[g] & en_i[g] & ~lvl_i[g];
  end

  logic hi_ok, lo_ok;
  // High requests may enter unless a high routine runs; low ones only when idle.
  assign hi_ok = (|hi_mask) & ~insvc_i[1];
  assign lo_ok = (|lo_mask) & ~insvc_i[1] & ~insvc_i[0];

  always_comb begin
    vld_o = hi_ok | lo_ok;
    lvl_o = hi_ok;
    if (hi_ok) idx_o = IW'(lowest_set(32'(hi_mask)));
    else       idx_o = IW'(lowest_set(32'(lo_mask)));
  end
endmodule

// File: rtl/arb_insvc_track.sv
module arb_insvc_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  logic       set_lvl_i,
  input  logic       reti_i,
  output logic [1:0] insvc_o
);
  logic [1:0] clr, set;

  always_comb begin
    clr = 2'b00;
    if (reti_i) clr = insvc_o[1] ? 2'b10 : 2'b01;
    set = 2'b00;
    if (set_i) set = set_lvl_i ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insvc_o <= 2'b00;
    else        insvc_o <= (insvc_o & ~clr) | set;
  end
endmodule

// File: rtl/int_prio_arb.sv
module int_prio_arb
  import int_prio_arb_pkg::*;
#(
  parameter int              NSRC     = 8,
  parameter int              ADDR_W   = 16,
  parameter logic [31:0]     VEC_BASE = 32'h0003,
  parameter int              VEC_STEP = 8,
  parameter int              MC_LEN   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NSRC-1:0]   lvl_i,
  input  logic              glob_en_i,
  input  logic              reti_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [NSRC-1:0]   src_ack_o,
  output logic [1:0]        insvc_o
);
  localparam int IW = $clog2(NSRC);

  // Named internal events
  logic          mc_tick;
  logic          sel_vld;
  logic [IW-1:0] sel_idx;
  logic          sel_lvl;
  logic          grant_fire;

  arb_mc_timer #(.MC_LEN(MC_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_o(mc_tick)
  );

  arb_prio_select #(.NSRC(NSRC)) u_sel (
    .req_i(req_i), .en_i(en_i), .lvl_i(lvl_i), .glob_en_i(glob_en_i),
    .insvc_i(insvc_o), .vld_o(sel_vld), .idx_o(sel_idx), .lvl_o(sel_lvl)
  );

  assign grant_fire = mc_tick & sel_vld;

  arb_insvc_track u_isv (
    .clk(clk), .rst_n(rst_n), .set_i(grant_fire), .set_lvl_i(sel_lvl),
    .reti_i(reti_i), .insvc_o(insvc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o     <= 1'b0;
      vec_o     <= '0;
      src_ack_o <= '0;
    end else begin
      ack_o     <= grant_fire;
      src_ack_o <= grant_fire ? (NSRC'(1) << sel_idx) : '0;
      if (grant_fire)
        vec_o <= ADDR_W'(vec_of(32'(sel_idx), VEC_BASE, VEC_STEP));
    end
  end
endmodule

// File: rtl/int_prio_arb_chk.sv
module int_prio_arb_chk
  import int_prio_arb_pkg::*;
#(
  parameter int          NSRC     = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [31:0] VEC_BASE = 32'h0003,
  parameter int          VEC_STEP = 8,
  parameter int          MC_LEN   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reti_i,
  input logic              ack_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [NSRC-1:0]   src_ack_o,
  input logic [1:0]        insvc_o
);
  localparam int GW = $clog2(MC_LEN + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (ack_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GMAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  a_r9_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $countones(src_ack_o) == 1);
  a_r9_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> src_ack_o == '0);
  a_r9_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> insvc_o != 2'b00);
  a_r2_vec_match: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> vec_o == ADDR_W'(vec_of(32'(lowest_set(32'(src_ack_o))), VEC_BASE, VEC_STEP)));
  a_r10_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> $stable(vec_o));
  a_r10_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && seen_q) |-> gap_q >= GW'(MC_LEN - 1));
  a_r7_hi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    insvc_o[1] |=> !ack_o);
  a_r6_lo_only_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_o == 2'b01) |=> (!ack_o || insvc_o[1]));
  a_r8_ret_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && insvc_o[1]) |=> (!insvc_o[1] && (insvc_o[0] == $past(insvc_o[0]))));
  a_r8_ret_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && insvc_o == 2'b01) |=> !insvc_o[0]);
endmodule

bind int_prio_arb int_prio_arb_chk #(
  .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
  .VEC_STEP(VEC_STEP), .MC_LEN(MC_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reti_i(reti_i), .ack_o(ack_o),
  .vec_o(vec_o), .src_ack_o(src_ack_o), .insvc_o(insvc_o)
);

// File: tb/int_prio_arb_tb_top.sv
`timescale 1ns/1ps
module int_prio_arb_tb_top;
  localparam int NSRC = 8;
  localparam int MC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] req = '0, en = '0, lvl = '0;
  logic glob_en = 1'b0, reti = 1'b0;
  logic ack;
  logic [15:0] vec;
  logic [NSRC-1:0] sack;
  logic [1:0] insvc;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  int_prio_arb #(.NSRC(NSRC), .MC_LEN(MC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .lvl_i(lvl),
    .glob_en_i(glob_en), .reti_i(reti), .ack_o(ack), .vec_o(vec),
    .src_ack_o(sack), .insvc_o(insvc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Wait up to a limit for an acknowledge, sampling at negedge.
  task automatic wait_ack(input int lim, output bit got, output int waited);
    got = 0; waited = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      waited = k + 1;
      if (ack) begin got = 1; break; end
    end
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  // Expect a grant to source idx with the given in-service state.
  task automatic expect_grant(input int idx, input logic [1:0] isv, input string tag);
    bit got; int w;
    wait_ack(2*MC + 2, got, w);
    chk(got, {tag, " ack seen"}, got, 1);
    chk(vec == 16'(3 + 8*idx), {tag, " vector"}, vec, 3 + 8*idx);
    chk(sack == NSRC'(1 << idx), {tag, " src_ack"}, sack, 1 << idx);
    chk(insvc == isv, {tag, " insvc"}, insvc, isv);
    req[idx] = 1'b0; // peripheral clears its flag
  endtask

  task automatic expect_none(input string tag);
    bit got; int w;
    wait_ack(3*MC, got, w);
    chk(!got, tag, got, 0);
  endtask

  task automatic t_reset();
    chk(ack == 0 && sack == 0, "R1 ack/src_ack at reset", {ack, sack}, 0);
    chk(insvc == 0, "R1 insvc at reset", insvc, 0);
    chk(vec == 0, "R1 vec at reset", vec, 0);
  endtask

  task automatic t_vectors(); // R2, R9, R8
    for (int i = 0; i < NSRC; i++) begin
      req[i] = 1'b1;
      expect_grant(i, 2'b01, "R2 R9 vector sweep");
      pulse_reti();
      chk(insvc == 2'b00, "R8 return clears low", insvc, 0);
    end
  endtask

  task automatic t_poll(); // R3
    req = 8'b1010_1100;
    expect_grant(2, 2'b01, "R3 lowest index first");
    pulse_reti();
    expect_grant(3, 2'b01, "R3 next in order");
    pulse_reti();
    req = '0;
    @(negedge clk);
  endtask

  task automatic t_level(); // R4, R7
    lvl = 8'b0100_0000;
    req = 8'b0100_0001;
    expect_grant(6, 2'b10, "R4 high beats low");
    req[2] = 1'b1; lvl[2] = 1'b1;
    expect_none("R7 high in service blocks all");
    pulse_reti();
    chk(insvc == 2'b00, "R8 return clears high", insvc, 0);
    expect_grant(2, 2'b10, "R4 second high after return");
    pulse_reti();
    expect_grant(0, 2'b01, "R4 low served last");
    pulse_reti();
    lvl = '0;
  endtask

  task automatic t_mask(); // R5
    en = 8'b1111_0111;
    req = 8'b0000_1000;
    expect_none("R5 disabled source ignored");
    en = '1;
    glob_en = 1'b0;
    expect_none("R5 global enable off");
    chk(insvc == 0, "R5 nothing entered service", insvc, 0);
    glob_en = 1'b1;
    expect_grant(3, 2'b01, "R5 grant once enabled");
    pulse_reti();
  endtask

  task automatic t_preempt(); // R6, R8
    req[4] = 1'b1;
    expect_grant(4, 2'b01, "R6 low enters");
    req[1] = 1'b1;
    expect_none("R6 low cannot preempt low");
    lvl[5] = 1'b1; req[5] = 1'b1;
    expect_grant(5, 2'b11, "R6 high preempts low");
    pulse_reti();
    chk(insvc == 2'b01, "R8 single return clears only high", insvc, 1);
    expect_none("R6 pending low still waits");
    pulse_reti();
    chk(insvc == 2'b00, "R8 second return clears low", insvc, 0);
    expect_grant(1, 2'b01, "R6 waiting low served");
    pulse_reti();
    lvl = '0;
  endtask

  task automatic t_timing(); // R10
    bit got; int w; logic [15:0] held;
    repeat (3) @(negedge clk);
    req[7] = 1'b1;
    wait_ack(3*MC, got, w);
    chk(got && w <= MC + 1, "R10 latency bound", w, MC + 1);
    req[7] = 1'b0;
    held = vec;
    for (int k = 0; k < 3*MC; k++) begin
      @(negedge clk);
      chk(vec == held && !ack, "R10 vector held", vec, held);
    end
    pulse_reti();
  endtask

  initial begin : main
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        en = '1; glob_en = 1'b1;
        t_vectors();
        t_poll();
        t_level();
        t_mask();
        t_preempt();
        t_timing();
      end
      begin
        repeat (20000) @(negedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule